// File: doc/BRIEF.md
# Two-Table Configurable Logic Cell

This block is a small programmable logic cell. Two 8-entry, single-bit lookup tables share a 3-bit select input. A fourth data input picks which table feeds the cell's main function output. Because of that pick, the cell can realise any 4-input combinational function. One table also drives a dedicated carry output, so a single cell forms a full adder: the incoming carry goes on one select bit, the table holding the carry truth table drives the carry output, and the other table gives the sum.

A flip-flop can register the selected function value. Configuration chooses:
- which clock edge the flip-flop captures on;
- whether the clock-enable input is honoured;
- whether the set/reset input acts, at which polarity, and whether it sets or clears the flip-flop.

The function output is either the combinational value or the registered value.

All of this is set by a 22-bit configuration word loaded one bit per clock through a serial port. While the word is being loaded the cell is idle: every output reads 0 and the flip-flop is cleared. The asynchronous reset clears both the configuration word and the flip-flop.

Top module: `lut2_cell`

## Requirements
- R1: While `cfg_shift` is 1, each rising `clk` edge shifts `cfg_bit` into a 22-bit word. After 22 shifts the first bit shifted holds sum-table entry 7, and the following bits hold sum-table entries 6 down to 0, then carry-table entries 7 down to 0, then control bits 5 down to 0. The last bit shifted is control bit 0. While `cfg_shift` is 0 the word does not change.
- R2: While `cfg_shift` is 1, `carry_out`, `sum_out` and `reg_out` are 0. Any active flip-flop edge during loading clears the flip-flop.
- R3: Outside loading, `carry_out` equals carry-table entry n, where n = 4*sel_in[2] + 2*sel_in[1] + sel_in[0].
- R4: With control bit 5 at 0, `sum_out` is sum-table entry n when `d3_in` is 1, and carry-table entry n when `d3_in` is 0.
- R5: With control bit 5 at 1, `sum_out` follows the flip-flop and equals `reg_out`. The flip-flop's data is the value that R4 describes.
- R6: Control bit 0 at 0 makes the flip-flop capture on the rising `clk` edge. At 1 it captures on the falling edge.
- R7: With control bit 3 at 1, the flip-flop captures only when `ce_in` is 1 and otherwise holds. With control bit 3 at 0, `ce_in` has no effect.
- R8: With control bit 4 at 1, set/reset is active when `sr_in` XOR control bit 1 is 1. On an active edge it then loads control bit 2 into the flip-flop (1 sets, 0 clears), whatever `ce_in` is. With control bit 4 at 0, `sr_in` has no effect.
- R9: With the sum table at 10010110 and the carry table at 01101001 (entry 7 first), `sum_out` (with `d3_in` = 1) and `carry_out` differ for all 8 select values. With the carry table at 11101000, the cell adds the three select bits: the carry is the majority and the sum is the XOR.
- R10: Asserting `rst_n` low clears the configuration word and the flip-flop at once, so all outputs read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for loading and for the flip-flop |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_shift | input | 1 | Load enable for the serial configuration word |
| cfg_bit | input | 1 | Serial configuration data |
| sel_in | input | 3 | Table select inputs (bit 0 may carry the incoming carry) |
| d3_in | input | 1 | Fourth input, picks the table feeding the function output |
| ce_in | input | 1 | Flip-flop clock enable |
| sr_in | input | 1 | Flip-flop synchronous set/reset request |
| carry_out | output | 1 | Carry-table output |
| sum_out | output | 1 | Function output, combinational or registered |
| reg_out | output | 1 | Flip-flop output |

## Verification
The flip-flop properties are checked only in rising-edge mode, on the main clock. They assume the configuration word changes only while loading, so the control bits read at one edge still hold at the next. The stimulus reconfigures only through full 22-bit loads. It changes data inputs only a quarter period after the rising edge, so that both capture edges see settled values. A reference model is kept in the bench. It tracks the shifted word and the flip-flop state on the active edge of each mode. It is compared on every cycle against all three outputs.

// File: rtl/lut2_pkg.sv
package lut2_pkg;
    parameter int LUT_IN = 3;
    localparam int LUT_N = 1 << LUT_IN;
    localparam int CTRL_W = 6;
    localparam int CFG_W = 2 * LUT_N + CTRL_W;

    localparam int CB_EDGE   = 0;
    localparam int CB_SRINV  = 1;
    localparam int CB_SRSET  = 2;
    localparam int CB_CEEN   = 3;
    localparam int CB_SREN   = 4;
    localparam int CB_REGOUT = 5;

    typedef struct packed {
        logic [LUT_N-1:0]  s_tab;
        logic [LUT_N-1:0]  c_tab;
        logic [CTRL_W-1:0] ctrl;
    } cell_cfg_t;
endpackage

// File: rtl/lut2_cfg_chain.sv
module lut2_cfg_chain #(
    parameter int W = 22
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         shift_bit,
    output logic [W-1:0] cfg_o
);
    typedef struct packed {
        logic [W-1:0] word;
    } chain_st_t;

    chain_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift_en) begin
            st_d.word = {st_q.word[W-2:0], shift_bit};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_o = st_q.word;
endmodule

// File: rtl/lut2_table.sv
module lut2_table #(
    parameter int IN = 3,
    localparam int N = 1 << IN
) (
    input  logic [N-1:0]  table_i,
    input  logic [IN-1:0] addr_i,
    output logic          bit_o
);
    always_comb begin
        bit_o = table_i[addr_i];
    end
endmodule

// File: rtl/lut2_ff.sv
module lut2_ff
    import lut2_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold_i,
    input  logic [CTRL_W-1:0] ctrl_i,
    input  logic              d_i,
    input  logic              ce_i,
    input  logic              sr_i,
    output logic              q_o
);
    typedef struct packed {
        logic q;
    } ff_st_t;

    ff_st_t st_d, st_q;
    logic   ff_clk;
    logic   sr_hit;
    logic   cap_en;

    assign ff_clk = clk ^ ctrl_i[CB_EDGE];

    always_comb begin
        st_d   = st_q;
        sr_hit = ctrl_i[CB_SREN] & (sr_i ^ ctrl_i[CB_SRINV]);
        cap_en = !ctrl_i[CB_CEEN] || ce_i;
        if (hold_i) begin
            st_d.q = 1'b0;
        end else if (sr_hit) begin
            st_d.q = ctrl_i[CB_SRSET];
        end else if (cap_en) begin
            st_d.q = d_i;
        end
    end

    always_ff @(posedge ff_clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q_o = st_q.q;
endmodule

// File: rtl/lut2_cell.sv
module lut2_cell
    import lut2_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_shift,
    input  logic              cfg_bit,
    input  logic [LUT_IN-1:0] sel_in,
    input  logic              d3_in,
    input  logic              ce_in,
    input  logic              sr_in,
    output logic              carry_out,
    output logic              sum_out,
    output logic              reg_out
);
    logic [CFG_W-1:0] cfg_vec;
    cell_cfg_t        cfg_w;
    logic [1:0]       lut_bit;
    logic             f4;
    logic             ff_q;

    lut2_cfg_chain #(.W(CFG_W)) u_chain (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (cfg_shift),
        .shift_bit (cfg_bit),
        .cfg_o     (cfg_vec)
    );

    assign cfg_w = cfg_vec;

    for (genvar g = 0; g < 2; g++) begin : g_lut
        lut2_table #(.IN(LUT_IN)) u_tab (
            .table_i ((g == 0) ? cfg_w.c_tab : cfg_w.s_tab),
            .addr_i  (sel_in),
            .bit_o   (lut_bit[g])
        );
    end

    assign f4 = d3_in ? lut_bit[1] : lut_bit[0];

    lut2_ff u_ff (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold_i (cfg_shift),
        .ctrl_i (cfg_w.ctrl),
        .d_i    (f4),
        .ce_i   (ce_in),
        .sr_i   (sr_in),
        .q_o    (ff_q)
    );

    assign carry_out = !cfg_shift & lut_bit[0];
    assign sum_out   = !cfg_shift & (cfg_w.ctrl[CB_REGOUT] ? ff_q : f4);
    assign reg_out   = !cfg_shift & ff_q;
endmodule

// File: rtl/lut2_cell_chk.sv
module lut2_cell_chk
    import lut2_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_shift,
    input logic              cfg_bit,
    input logic [LUT_IN-1:0] sel_in,
    input logic              ce_in,
    input logic              sr_in,
    input logic              carry_out,
    input logic              sum_out,
    input logic              reg_out,
    input logic [CFG_W-1:0]  cfg_q
);
    // R1
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_shift |=> $stable(cfg_q));

    // R1
    cfg_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_shift |=> (cfg_q[0] == $past(cfg_bit)) &&
                      (cfg_q[CFG_W-1:1] == $past(cfg_q[CFG_W-2:0])));

    // R2
    load_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_shift |-> !carry_out && !sum_out && !reg_out);

    // R3
    carry_tab_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_shift |-> carry_out == cfg_q[CTRL_W + int'(sel_in)]);

    // R8
    sr_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_shift && !cfg_q[CB_EDGE] && cfg_q[CB_SREN] && (sr_in ^ cfg_q[CB_SRINV]))
        |=> cfg_shift || (reg_out == $past(cfg_q[CB_SRSET])));

    // R7
    ce_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_shift && !cfg_q[CB_EDGE] && cfg_q[CB_CEEN] && !ce_in &&
         !(cfg_q[CB_SREN] && (sr_in ^ cfg_q[CB_SRINV])))
        |=> cfg_shift || $stable(reg_out));
endmodule

bind lut2_cell lut2_cell_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_shift (cfg_shift),
    .cfg_bit   (cfg_bit),
    .sel_in    (sel_in),
    .ce_in     (ce_in),
    .sr_in     (sr_in),
    .carry_out (carry_out),
    .sum_out   (sum_out),
    .reg_out   (reg_out),
    .cfg_q     (cfg_vec)
);

// File: tb/lut2_cell_bench.sv
`timescale 1ns/1ps
module lut2_cell_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic b_shift = 1'b0, b_bit = 1'b0, b_d3 = 1'b0, b_ce = 1'b0, b_sr = 1'b0;
    logic [2:0] b_sel = 3'd0;
    logic carry_out, sum_out, reg_out;

    int nvec = 0;
    int nfail = 0;
    logic [21:0] mcfg = '0;
    logic mq = 1'b0;

    always #2 clk = ~clk;

    lut2_cell u_lut2_cell (
        .clk(clk), .rst_n(rst_n), .cfg_shift(b_shift), .cfg_bit(b_bit),
        .sel_in(b_sel), .d3_in(b_d3), .ce_in(b_ce), .sr_in(b_sr),
        .carry_out(carry_out), .sum_out(sum_out), .reg_out(reg_out)
    );

    function automatic logic m_f4();
        int n = int'(b_sel);
        return b_d3 ? mcfg[14 + n] : mcfg[6 + n];
    endfunction

    function automatic logic m_next();
        if (mcfg[4] && (b_sr ^ mcfg[1])) return mcfg[2];
        if (!mcfg[3] || b_ce) return m_f4();
        return mq;
    endfunction

    task automatic check(input string tag, input string what, input logic got, input logic exp);
        nvec++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s %s: got %0b expected %0b at %0t", tag, what, got, exp, $time);
        end
    endtask

    task automatic compare(input string tag);
        logic ec, es, er;
        ec = b_shift ? 1'b0 : mcfg[6 + int'(b_sel)];
        er = b_shift ? 1'b0 : mq;
        es = b_shift ? 1'b0 : (mcfg[5] ? mq : m_f4());
        check(tag, "carry_out", carry_out, ec);
        check(tag, "sum_out", sum_out, es);
        check(tag, "reg_out", reg_out, er);
    endtask

    task automatic step(input string tag, input logic sh, input logic bt, input logic [2:0] s,
                        input logic d3, input logic ce, input logic sr);
        @(posedge clk);
        if (b_shift) begin
            mcfg = {mcfg[20:0], b_bit};
            mq = 1'b0;
        end else if (!mcfg[0]) begin
            mq = m_next();
        end
        #1;
        b_shift = sh; b_bit = bt; b_sel = s; b_d3 = d3; b_ce = ce; b_sr = sr;
        #2;
        if (b_shift) mq = 1'b0;
        else if (mcfg[0]) mq = m_next();
        compare(tag);
    endtask

    task automatic load(input logic [7:0] st, input logic [7:0] ct, input logic [5:0] cb);
        logic [21:0] w = {st, ct, cb};
        for (int i = 21; i >= 0; i--) step("R2", 1'b1, w[i], 3'(i), i[0], 1'b1, 1'b1);
        step("R1", 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0);
        nvec++;
        if (mcfg !== w) begin
            nfail++;
            $display("FAIL R1 model word: got %h expected %h", mcfg, w);
        end
    endtask

    initial begin
        #800000;
        nfail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #3;
        compare("R10");
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) step("R10", 1'b0, 1'b0, 3'(i), 1'b1, 1'b1, 1'b0);

        // R9 and R3/R4: complementary tables, combinational output
        load(8'b10010110, 8'b01101001, 6'b000000);
        for (int i = 0; i < 8; i++) begin
            step("R3", 1'b0, 1'b0, 3'(i), 1'b1, 1'b0, 1'b0);
            nvec++;
            if (sum_out === carry_out) begin
                nfail++;
                $display("FAIL R9 opposite: got %0b/%0b expected differing", sum_out, carry_out);
            end
        end
        for (int i = 0; i < 8; i++) step("R4", 1'b0, 1'b0, 3'(i), 1'b0, 1'b0, 1'b0);

        // R9 full adder
        load(8'b10010110, 8'b11101000, 6'b000000);
        for (int i = 0; i < 8; i++) begin
            step("R9", 1'b0, 1'b0, 3'(i), 1'b1, 1'b0, 1'b0);
            check("R9", "adder sum", sum_out, ^3'(i));
            check("R9", "adder carry", carry_out, ($countones(3'(i)) >= 2));
        end

        // R5/R6 rising registered
        load(8'b10110100, 8'b01011001, 6'b100000);
        for (int i = 0; i < 16; i++) step("R6", 1'b0, 1'b0, 3'(i * 5), i[1], 1'b0, 1'b1);

        // R6 falling registered, R5
        load(8'b10110100, 8'b01011001, 6'b100001);
        for (int i = 0; i < 16; i++) step("R5", 1'b0, 1'b0, 3'(i * 3), i[2], 1'b0, 1'b1);

        // R7 clock enable honoured, then ignored
        load(8'b11110000, 8'b00001111, 6'b101000);
        for (int i = 0; i < 16; i++) step("R7", 1'b0, 1'b0, 3'(i), 1'b1, i[1] & i[0], 1'b0);
        load(8'b11110000, 8'b00001111, 6'b100000);
        for (int i = 0; i < 12; i++) step("R7", 1'b0, 1'b0, 3'(i * 3), 1'b1, 1'b0, 1'b0);

        // R8 reset over disabled CE, active high
        load(8'b11111111, 8'b11111111, 6'b111000);
        for (int i = 0; i < 12; i++) step("R8", 1'b0, 1'b0, 3'(i), 1'b1, i[0], (i % 4) == 2);
        // R8 set, active low, falling edge
        load(8'b00000000, 8'b00000000, 6'b110111);
        for (int i = 0; i < 12; i++) step("R8", 1'b0, 1'b0, 3'(i), 1'b1, i[0], (i % 3) != 1);
        // R8 set/reset disabled: sr ignored
        load(8'b00000000, 8'b00000000, 6'b100110);
        for (int i = 0; i < 6; i++) step("R8", 1'b0, 1'b0, 3'(i), 1'b1, 1'b1, 1'b1);

        // R2 load while flip-flop holds 1
        load(8'b11111111, 8'b11111111, 6'b100000);
        step("R2", 1'b0, 1'b0, 3'd1, 1'b1, 1'b1, 1'b0);
        step("R2", 1'b0, 1'b0, 3'd1, 1'b1, 1'b1, 1'b0);
        load(8'b00000000, 8'b11111111, 6'b000000);
        step("R2", 1'b0, 1'b0, 3'd2, 1'b1, 1'b0, 1'b0);

        // R10 reset mid-run
        load(8'b11111111, 8'b11111111, 6'b100000);
        step("R10", 1'b0, 1'b0, 3'd3, 1'b1, 1'b1, 1'b0);
        @(posedge clk);
        #1;
        rst_n = 1'b0;
        mcfg = '0;
        mq = 1'b0;
        #2;
        compare("R10");
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        for (int i = 0; i < 8; i++) step("R10", 1'b0, 1'b0, 3'(i), i[0], 1'b1, 1'b0);

        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule